// File: doc/BRIEF.md
# PCI-to-ISA Bridge Configuration Register File

This block holds the 256-byte configuration space of a single-function PCI-to-ISA bridge. Each byte-wide access carries a function number and an 8-bit register offset. A write passes through a per-offset write policy before it reaches storage. Depending on the offset, the policy stores the byte unchanged, drops it, forces it to a constant, masks it, or commits it only when one bit toggles. Reads return the stored byte one cycle later. A read aimed at any function other than zero returns all ones.

Four interrupt steering registers drive four pin outputs. Each pin output is an enable plus a 4-bit IRQ number. The offset-to-pin order is deliberately not sequential. Two further level outputs follow individual stored bits: a DMA register alias enable and a fast reset/A20 port enable. Reset loads a fixed table of default bytes.

Read sequencing uses a two-state machine. `RD_IDLE` is the state with no result pending. `RD_HOLD` is the cycle in which the read result is presented. The transitions are:
- `RD_IDLE` to `RD_HOLD` on a read request.
- `RD_HOLD` to `RD_HOLD` on a back-to-back read request.
- `RD_HOLD` to `RD_IDLE` when no read is requested.

The write policies are `WP_PLAIN`, `WP_DROP`, `WP_CMD`, `WP_ZERO`, `WP_CONST2` and `WP_TOGGLE`.

Top module: `cfg_bridge_regs`

## Requirements
- R1: After reset, offsets 0x00..0x03 read 0x86, 0x80, 0x84, 0x04. Offset 0x04 reads 0x07, 0x07 reads 0x02 and 0x08 reads 0x03. Offsets 0x60..0x63 read 0x80. Further defaults are 0x40=0x20, 0x42=0x04, 0x44=0x20, 0x45=0x10, 0x46=0x0F, 0x48=0x01, 0x49=0x10, 0x4A=0x10, 0x4B=0x0F, 0x4C=0x56, 0x4D=0x40, 0x4E=0x07, 0x4F=0x4F, 0x80=0x78, 0xA0=0x08 and 0xA8=0x0F. Every other offset reads 0x00.
- R2: A write with a nonzero function number changes nothing. A read with a nonzero function number returns 0xFF.
- R3: Writes to offsets 0x00..0x03 and 0x08..0x4B leave the stored byte unchanged.
- R4: A write to offset 0x04 stores (data AND 0x08) OR 0x07.
- R5: A write to 0x05 or 0x06 stores 0x00. A write to 0x07 stores 0x02.
- R6: A write to any offset not covered by R3, R4, R5 or R8 stores the full byte.
- R7: Offsets 0x60, 0x61, 0x62 and 0x63 steer pins A, C, B and D respectively. Pin index 0=A, 1=B, 2=C, 3=D; pin p uses steer_irq[4p+3:4p]. For each pin, bit 7 set gives steer_en=0; bit 7 clear gives steer_en=1 with irq equal to bits 3:0. After reset all pins have en=0 and irq=0.
- R8: A write to 0x4F whose bit 6 equals the stored bit 6 is dropped entirely. Otherwise the byte is stored and fastport_on takes bit 6. Its reset value is 1.
- R9: dma_alias_on is the inverse of bit 6 of offset 0x40. It is 1 after reset and no write changes it.
- R10: A write to 0x4F leaves every steering output unchanged.
- R11: rd_valid and rd_data appear one cycle after rd_en. A write and a read to the same offset in one cycle return the old byte.
- R12: A steering output reflects a write at the sampling point right after the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| acc_fn | input | 3 | Function number of the access |
| acc_off | input | 8 | Register offset |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | High for the cycle rd_data holds a fresh result |
| steer_en | output | 4 | Per-pin enable, index 0=A..3=D |
| steer_irq | output | 16 | Per-pin IRQ number, 4 bits per pin |
| dma_alias_on | output | 1 | DMA register alias enable |
| fastport_on | output | 1 | Fast reset/A20 port enable |

## Verification
A write and a read can land on the same offset in the same cycle. The bench provokes this by driving both requests to one plain offset with a new byte. It judges the result by requiring the old byte in the read result and the new byte on a following read. A write to 0x4F arriving while steering registers hold programmed values also combines two functions, and the steering outputs are checked to stay put.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
    localparam int unsigned OFF_W  = 8;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned FN_W   = 3;
    localparam int unsigned NPIN   = 4;
    localparam int unsigned IRQ_W  = 4;
    localparam int unsigned DEPTH  = 1 << OFF_W;

    localparam logic [OFF_W-1:0] CMD_OFF    = 8'h04;
    localparam logic [OFF_W-1:0] ALIAS_OFF  = 8'h40;
    localparam logic [OFF_W-1:0] FAST_OFF   = 8'h4F;
    localparam logic [OFF_W-1:0] STEER_BASE = 8'h60;
    localparam int unsigned      CTL_BIT    = 6;

    typedef enum logic [2:0] {
        WP_PLAIN, WP_DROP, WP_CMD, WP_ZERO, WP_CONST2, WP_TOGGLE
    } wpol_e;

    typedef enum logic {RD_IDLE, RD_HOLD} rd_state_e;

    function automatic logic [DATA_W-1:0] reset_byte(input logic [OFF_W-1:0] off);
        unique case (off)
            8'h00: reset_byte = 8'h86;
            8'h01: reset_byte = 8'h80;
            8'h02: reset_byte = 8'h84;
            8'h03: reset_byte = 8'h04;
            8'h04: reset_byte = 8'h07;
            8'h07: reset_byte = 8'h02;
            8'h08: reset_byte = 8'h03;
            8'h40: reset_byte = 8'h20;
            8'h42: reset_byte = 8'h04;
            8'h44: reset_byte = 8'h20;
            8'h45: reset_byte = 8'h10;
            8'h46: reset_byte = 8'h0F;
            8'h48: reset_byte = 8'h01;
            8'h49: reset_byte = 8'h10;
            8'h4A: reset_byte = 8'h10;
            8'h4B: reset_byte = 8'h0F;
            8'h4C: reset_byte = 8'h56;
            8'h4D: reset_byte = 8'h40;
            8'h4E: reset_byte = 8'h07;
            8'h4F: reset_byte = 8'h4F;
            8'h60, 8'h61, 8'h62, 8'h63: reset_byte = 8'h80;
            8'h80: reset_byte = 8'h78;
            8'hA0: reset_byte = 8'h08;
            8'hA8: reset_byte = 8'h0F;
            default: reset_byte = 8'h00;
        endcase
    endfunction

    function automatic wpol_e policy_of(input logic [OFF_W-1:0] off);
        if (off <= 8'h03 || (off >= 8'h08 && off <= 8'h4B))
            policy_of = WP_DROP;
        else if (off == CMD_OFF)
            policy_of = WP_CMD;
        else if (off == 8'h05 || off == 8'h06)
            policy_of = WP_ZERO;
        else if (off == 8'h07)
            policy_of = WP_CONST2;
        else if (off == FAST_OFF)
            policy_of = WP_TOGGLE;
        else
            policy_of = WP_PLAIN;
    endfunction
endpackage

// File: rtl/cfg_write_policy.sv
module cfg_write_policy
    import cfg_bridge_pkg::*;
(
    input  logic              wr_en,
    input  logic [FN_W-1:0]   acc_fn,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cur_ctl_bit,
    output logic              commit,
    output logic [DATA_W-1:0] commit_data
);
    wpol_e pol;

    always_comb begin
        pol         = policy_of(acc_off);
        commit      = 1'b0;
        commit_data = wr_data;
        if (wr_en && acc_fn == '0) begin
            unique case (pol)
                WP_PLAIN:  commit = 1'b1;
                WP_DROP:   commit = 1'b0;
                WP_CMD: begin
                    commit      = 1'b1;
                    commit_data = (wr_data & 8'h08) | 8'h07;
                end
                WP_ZERO: begin
                    commit      = 1'b1;
                    commit_data = '0;
                end
                WP_CONST2: begin
                    commit      = 1'b1;
                    commit_data = 8'h02;
                end
                WP_TOGGLE: commit = (wr_data[CTL_BIT] != cur_ctl_bit);
                default:   commit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
    import cfg_bridge_pkg::*;
#(
    parameter int unsigned DEPTH_P = DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [OFF_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic              rd_fn_ok,
    input  logic [OFF_W-1:0]  raddr,
    output logic [DATA_W-1:0] rd_data,
    output logic              fast_bit,
    output logic              alias_bit
);
    logic [DATA_W-1:0] mem [DEPTH_P];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH_P); i++)
                mem[i] <= reset_byte(OFF_W'(i));
        end else if (commit) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_fn_ok ? mem[raddr] : '1;
    end

    assign fast_bit  = mem[FAST_OFF][CTL_BIT];
    assign alias_bit = mem[ALIAS_OFF][CTL_BIT];

    // R2
    fn_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rd_fn_ok |=> rd_data == 8'hFF);
endmodule

// File: rtl/cfg_steer.sv
module cfg_steer
    import cfg_bridge_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [OFF_W-1:0]      waddr,
    input  logic                  dis_bit,
    input  logic [IRQ_W-1:0]      irq_val,
    output logic [NPIN-1:0]       steer_en,
    output logic [NPIN*IRQ_W-1:0] steer_irq
);
    for (genvar p = 0; p < int'(NPIN); p++) begin : g_pin
        localparam int K = ((p & 1) << 1) | ((p >> 1) & 1);
        localparam logic [OFF_W-1:0] MY_OFF = STEER_BASE + OFF_W'(K);
        logic hit;
        assign hit = commit && (waddr == MY_OFF);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                steer_en[p]                  <= 1'b0;
                steer_irq[p*IRQ_W +: IRQ_W]  <= '0;
            end else if (hit) begin
                steer_en[p]                  <= ~dis_bit;
                steer_irq[p*IRQ_W +: IRQ_W]  <= irq_val;
            end
        end

        // R7
        steer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            commit && waddr == MY_OFF |=> steer_en[p] == !$past(dis_bit));
    end
endmodule

// File: rtl/cfg_bridge_regs.sv
module cfg_bridge_regs
    import cfg_bridge_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [FN_W-1:0]       acc_fn,
    input  logic [OFF_W-1:0]      acc_off,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_valid,
    output logic [NPIN-1:0]       steer_en,
    output logic [NPIN*IRQ_W-1:0] steer_irq,
    output logic                  dma_alias_on,
    output logic                  fastport_on
);
    logic              commit;
    logic [DATA_W-1:0] commit_data;
    logic              fast_bit;
    logic              alias_bit;
    logic              fast_q;
    rd_state_e         rd_state, rd_next;

    cfg_write_policy u_policy (
        .wr_en       (wr_en),
        .acc_fn      (acc_fn),
        .acc_off     (acc_off),
        .wr_data     (wr_data),
        .cur_ctl_bit (fast_bit),
        .commit      (commit),
        .commit_data (commit_data)
    );

    cfg_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .waddr     (acc_off),
        .wdata     (commit_data),
        .rd_en     (rd_en),
        .rd_fn_ok  (acc_fn == '0),
        .raddr     (acc_off),
        .rd_data   (rd_data),
        .fast_bit  (fast_bit),
        .alias_bit (alias_bit)
    );

    cfg_steer u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .waddr     (acc_off),
        .dis_bit   (commit_data[7]),
        .irq_val   (commit_data[IRQ_W-1:0]),
        .steer_en  (steer_en),
        .steer_irq (steer_irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            fast_q <= reset_byte(FAST_OFF)[CTL_BIT];
        else if (commit && acc_off == FAST_OFF)
            fast_q <= commit_data[CTL_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_state <= RD_IDLE;
        else        rd_state <= rd_next;
    end

    always_comb begin
        unique case (rd_state)
            RD_IDLE: rd_next = rd_en ? RD_HOLD : RD_IDLE;
            RD_HOLD: rd_next = rd_en ? RD_HOLD : RD_IDLE;
            default: rd_next = RD_IDLE;
        endcase
    end

    always_comb begin
        rd_valid     = (rd_state == RD_HOLD);
        fastport_on  = fast_q;
        dma_alias_on = ~alias_bit;
    end

    // R2
    fn_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && acc_fn != '0 |=> $stable(steer_en) && $stable(steer_irq) && $stable(fastport_on));
    // R8
    fast_same_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && acc_fn == '0 && acc_off == FAST_OFF && wr_data[CTL_BIT] == fastport_on
        |=> $stable(fastport_on));
    // R8
    fast_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && acc_fn == '0 && acc_off == FAST_OFF
        |=> fastport_on == $past(wr_data[CTL_BIT]));
    // R10
    fast_no_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && acc_off == FAST_OFF |=> $stable(steer_en) && $stable(steer_irq));
    // R9
    alias_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> dma_alias_on);
    // R11
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
endmodule

// File: tb/cfg_bridge_regs_test.sv
`timescale 1ns/1ps
module cfg_bridge_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  acc_fn = '0;
    logic [7:0]  acc_off = '0, wr_data = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [3:0]  steer_en;
    logic [15:0] steer_irq;
    logic        dma_alias_on, fastport_on;

    int          n_run = 0, n_fail = 0;
    bit          done = 0;
    logic [7:0]  q_exp[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    cfg_bridge_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .acc_fn(acc_fn), .acc_off(acc_off), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .steer_en(steer_en),
        .steer_irq(steer_irq), .dma_alias_on(dma_alias_on),
        .fastport_on(fastport_on)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] fn, input logic [7:0] off, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; acc_fn = fn; acc_off = off; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; acc_fn = '0;
    endtask

    task automatic rd(input logic [2:0] fn, input logic [7:0] off,
                      input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; acc_fn = fn; acc_off = off;
        q_exp.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0; acc_fn = '0;
    endtask

    task automatic wr_rd(input logic [7:0] off, input logic [7:0] d,
                         input logic [7:0] exp, input string tag);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; acc_fn = '0; acc_off = off; wr_data = d;
        q_exp.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q_exp.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R11 unexpected read result actual=%h expected=none", rd_data);
            end else begin
                automatic logic [7:0] e = q_exp.pop_front();
                automatic string t = q_tag.pop_front();
                check(t, {8'h00, rd_data}, {8'h00, e});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R7 R9 R8 reset outputs
        check("R1 R7 steer_en reset", {12'h0, steer_en}, 16'h0);
        check("R7 steer_irq reset", steer_irq, 16'h0);
        check("R9 dma alias reset", {15'h0, dma_alias_on}, 16'h1);
        check("R8 fastport reset", {15'h0, fastport_on}, 16'h1);
        // R1 defaults
        rd(0, 8'h00, 8'h86, "R1 off00"); rd(0, 8'h01, 8'h80, "R1 off01");
        rd(0, 8'h02, 8'h84, "R1 off02"); rd(0, 8'h03, 8'h04, "R1 off03");
        rd(0, 8'h04, 8'h07, "R1 off04"); rd(0, 8'h07, 8'h02, "R1 off07");
        rd(0, 8'h08, 8'h03, "R1 off08"); rd(0, 8'h4C, 8'h56, "R1 off4C");
        rd(0, 8'h4F, 8'h4F, "R1 off4F"); rd(0, 8'h62, 8'h80, "R1 off62");
        rd(0, 8'h80, 8'h78, "R1 off80"); rd(0, 8'hA8, 8'h0F, "R1 offA8");
        rd(0, 8'h50, 8'h00, "R1 off50"); rd(0, 8'h41, 8'h00, "R1 off41");
        // R2 function number
        rd(3'd1, 8'h00, 8'hFF, "R2 fn1 read");
        wr(3'd2, 8'h60, 8'h05);
        check("R2 fn2 write steer", {12'h0, steer_en}, 16'h0);
        rd(0, 8'h60, 8'h80, "R2 fn2 write stored");
        // R3 protected
        wr(0, 8'h00, 8'h11); rd(0, 8'h00, 8'h86, "R3 off00");
        wr(0, 8'h30, 8'h5A); rd(0, 8'h30, 8'h00, "R3 off30");
        wr(0, 8'h4B, 8'hEE); rd(0, 8'h4B, 8'h0F, "R3 off4B");
        // R9 alias bit not writable
        wr(0, 8'h40, 8'h40); rd(0, 8'h40, 8'h20, "R9 off40");
        check("R9 dma alias after write", {15'h0, dma_alias_on}, 16'h1);
        // R4 command
        wr(0, 8'h04, 8'hFF); rd(0, 8'h04, 8'h0F, "R4 cmd FF");
        wr(0, 8'h04, 8'h00); rd(0, 8'h04, 8'h07, "R4 cmd 00");
        // R5 forced
        wr(0, 8'h05, 8'hAA); rd(0, 8'h05, 8'h00, "R5 off05");
        wr(0, 8'h06, 8'hFF); rd(0, 8'h06, 8'h00, "R5 off06");
        wr(0, 8'h07, 8'hFF); rd(0, 8'h07, 8'h02, "R5 off07");
        // R6 plain
        wr(0, 8'h50, 8'hA5); rd(0, 8'h50, 8'hA5, "R6 off50");
        wr(0, 8'hFF, 8'h3C); rd(0, 8'hFF, 8'h3C, "R6 offFF");
        // R7 R12 steering
        wr(0, 8'h61, 8'h0B);
        check("R12 R7 0x61 -> pin C en", {12'h0, steer_en}, 16'h0004);
        check("R7 0x61 -> pin C irq", steer_irq, 16'h0B00);
        wr(0, 8'h62, 8'h05);
        check("R7 0x62 -> pin B en", {12'h0, steer_en}, 16'h0006);
        check("R7 0x62 -> pin B irq", steer_irq, 16'h0B50);
        wr(0, 8'h60, 8'h03);
        wr(0, 8'h63, 8'h8E);
        check("R7 pins A and D en", {12'h0, steer_en}, 16'h0007);
        check("R7 pins irq", steer_irq, 16'hEB53);
        rd(0, 8'h63, 8'h8E, "R7 off63 stored");
        // R8 R10 toggle register
        wr(0, 8'h4F, 8'h40); rd(0, 8'h4F, 8'h4F, "R8 same bit dropped");
        check("R8 fastport kept", {15'h0, fastport_on}, 16'h1);
        wr(0, 8'h4F, 8'h0A);
        check("R8 fastport off", {15'h0, fastport_on}, 16'h0);
        check("R10 steer_en after 4F", {12'h0, steer_en}, 16'h0007);
        check("R10 steer_irq after 4F", steer_irq, 16'hEB53);
        rd(0, 8'h4F, 8'h0A, "R8 stored 0A");
        wr(0, 8'h4F, 8'h11); rd(0, 8'h4F, 8'h0A, "R8 clear bit dropped");
        wr(0, 8'h4F, 8'hC3);
        check("R8 fastport on", {15'h0, fastport_on}, 16'h1);
        check("R10 steer_irq after 4F again", steer_irq, 16'hEB53);
        rd(0, 8'h4F, 8'hC3, "R8 stored C3");
        // R11 same-cycle write and read
        wr_rd(8'h50, 8'h77, 8'hA5, "R11 old value");
        rd(0, 8'h50, 8'h77, "R11 new value");
        repeat (3) @(negedge clk);
        check("R11 scoreboard drained", 16'(q_exp.size()), 16'h0);
        finish_run();
    end
endmodule